// File: doc/BRIEF.md
# Prescaled one-shot/periodic timer

A 32-bit up-counting timer behind a byte-wide register port. Software loads a maximum value and a divide value, then starts the counter by setting one of two mode bits. In periodic mode the counter climbs from zero to the maximum and then restarts from zero. In single-shot mode it climbs once, parks at the maximum and drops its own mode bit. A divide value N slows the counter to one step every N+1 clocks.

Whenever the counter takes a step while it holds the maximum, a sticky match flag is set. This flag raises a level interrupt when interrupts are enabled. The count is read as four bytes. Reading the low byte captures the whole count into a shadow, so that a narrow bus reading the upper bytes afterwards sees one coherent value.

Top module: `pscl_timer`

## Requirements
- R1: After reset the control, interrupt-enable, match-flag, count and divide registers read 0x00, the four maximum bytes read 0xFF, and irq_o is low.
- R2: Control offset 0x0 bit 0 selects periodic mode. The count advances from 0 to the maximum, and the step taken at the maximum returns it to 0, with the mode kept.
- R3: Control bit 1 selects single-shot mode. The step taken at the maximum leaves the count at the maximum and clears bit 1, so the control register reads 0x00.
- R4: A control write with bit 1 set selects single-shot only; one with only bit 0 set selects periodic only. Either one restarts the count and the prescaler from 0. A write of 0 stops the counter, which then holds its value. The two mode bits are never both set.
- R5: With divide value N, the running count advances once every N+1 clocks, and holds its value between those steps.
- R6: The match flag (offset 0x2, bit 0) sets on the step the counter takes while it equals the maximum. It stays set until cleared.
- R7: The match flag clears on a write to 0x2 with bit 0 = 1, on a control write that sets a mode bit, or on a write to any maximum byte. A write of 0 to 0x2 or 0x0 leaves it set. A set in the same cycle wins over a clear.
- R8: Offset 0x1 bit 0 is the interrupt enable. irq_o is high exactly when the match flag and this enable are both 1.
- R9: The maximum is written and read as four bytes at 0x4..0x7, with the least significant byte at 0x4.
- R10: Reading 0x8 returns the live low count byte and latches the full count into a shadow. Reads of 0x9..0xB return shadow bytes 1..3.
- R11: The divide value is read and written at offset 0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe (latches the shadow on 0x8) |
| addr_i | input | ADDR_W (4) | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit count, an 8-bit divide and a 4-bit offset. It writes small maximum values (2, 3 and 5) so that wraps, single-shot stops and flag sets happen within a few cycles. It uses a divide of 2 to show the count holding between steps. To exercise the shadow path it lets the count run past 255 with the maximum at all ones, so the upper count bytes become non-zero. It then reads those bytes while the live count keeps moving.

// File: rtl/pscl_timer_pkg.sv
`timescale 1ns / 1ps
package pscl_timer_pkg;
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_IRQ_EN = 1;
  localparam int unsigned OFS_HIT    = 2;
  localparam int unsigned OFS_MAX    = 4;
  localparam int unsigned OFS_CNT    = 8;
  localparam int unsigned OFS_DIV    = 12;
  localparam int unsigned BIT_PER    = 0;
  localparam int unsigned BIT_ONE    = 1;
endpackage

// File: rtl/pscl_timer_regs.sv
`timescale 1ns / 1ps
module pscl_timer_regs
  import pscl_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              done_i,
  input  logic              hit_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              per_o,
  output logic              one_o,
  output logic              start_o,
  output logic              hit_clr_o,
  output logic              irq_en_o,
  output logic [CNT_W-1:0]  max_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [7:0]        rdata_o
);
  localparam int unsigned NB = CNT_W / 8;

  logic            wr_ctrl, wr_irq, wr_hit, wr_div, rd_cnt_lo;
  logic [NB-1:0]   wr_max;
  logic [7:0]      max_q [NB];
  logic [CNT_W-1:0] shadow_q;

  assign wr_ctrl   = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_irq    = wr_en_i && (addr_i == ADDR_W'(OFS_IRQ_EN));
  assign wr_hit    = wr_en_i && (addr_i == ADDR_W'(OFS_HIT));
  assign wr_div    = wr_en_i && (addr_i == ADDR_W'(OFS_DIV));
  assign rd_cnt_lo = rd_en_i && (addr_i == ADDR_W'(OFS_CNT));

  assign start_o   = wr_ctrl && (wdata_i[BIT_PER] || wdata_i[BIT_ONE]);
  assign hit_clr_o = (wr_hit && wdata_i[0]) || start_o || (|wr_max);

  for (genvar b = 0; b < NB; b++) begin : g_max
    assign wr_max[b] = wr_en_i && (addr_i == ADDR_W'(OFS_MAX + b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        max_q[b] <= 8'hFF;
      else if (wr_max[b]) max_q[b] <= wdata_i;
    end
    assign max_o[8*b +: 8] = max_q[b];
  end

  // single-shot wins when both bits are written; hardware clears it at the end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o <= 1'b0;
      one_o <= 1'b0;
    end else if (wr_ctrl) begin
      per_o <= wdata_i[BIT_PER] && !wdata_i[BIT_ONE];
      one_o <= wdata_i[BIT_ONE];
    end else if (done_i) begin
      one_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o <= 1'b0;
      div_o    <= '0;
      shadow_q <= '0;
    end else begin
      if (wr_irq)    irq_en_o <= wdata_i[0];
      if (wr_div)    div_o    <= wdata_i[DIV_W-1:0];
      if (rd_cnt_lo) shadow_q <= cnt_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CTRL))   rdata_o = {6'b0, one_o, per_o};
    if (addr_i == ADDR_W'(OFS_IRQ_EN)) rdata_o = {7'b0, irq_en_o};
    if (addr_i == ADDR_W'(OFS_HIT))    rdata_o = {7'b0, hit_i};
    if (addr_i == ADDR_W'(OFS_DIV))    rdata_o = 8'(div_o);
    for (int b = 0; b < NB; b++) begin
      if (addr_i == ADDR_W'(OFS_MAX + b)) rdata_o = max_q[b];
      if (addr_i == ADDR_W'(OFS_CNT + b))
        rdata_o = (b == 0) ? cnt_i[7:0] : shadow_q[8*b +: 8];
    end
  end
endmodule

// File: rtl/pscl_timer_presc.sv
`timescale 1ns / 1ps
module pscl_timer_presc #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_cnt_q;

  assign tick_o = run_i && (div_cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            div_cnt_q <= '0;
    else if (restart_i || !run_i || tick_o) div_cnt_q <= '0;
    else                                    div_cnt_q <= div_cnt_q + 1'b1;
  end
endmodule

// File: rtl/pscl_timer_core.sv
`timescale 1ns / 1ps
module pscl_timer_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             per_i,
  input  logic             one_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             hit_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             done_o
);
  logic run, at_max, end_step;

  assign run      = per_i || one_i;
  assign at_max   = (cnt_o == max_i);
  assign end_step = run && tick_i && at_max;
  assign done_o   = one_i && tick_i && at_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_o <= '0;
    else if (start_i)          cnt_o <= '0;
    else if (run && tick_i) begin
      if (at_max)              cnt_o <= per_i ? '0 : cnt_o;
      else                     cnt_o <= cnt_o + 1'b1;
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= 1'b0;
    else         hit_o <= end_step || (hit_o && !hit_clr_i);
  end
endmodule

// File: rtl/pscl_timer.sv
`timescale 1ns / 1ps
module pscl_timer #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  logic             per, one, start, hit_clr, irq_en, done, hit, tick;
  logic [CNT_W-1:0] max_val, cnt;
  logic [DIV_W-1:0] div_val;

  pscl_timer_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .done_i(done), .hit_i(hit), .cnt_i(cnt),
    .per_o(per), .one_o(one), .start_o(start), .hit_clr_o(hit_clr),
    .irq_en_o(irq_en), .max_o(max_val), .div_o(div_val), .rdata_o
  );

  pscl_timer_presc #(.DIV_W(DIV_W)) u_presc (
    .clk_i, .rst_ni, .run_i(per || one), .restart_i(start),
    .div_i(div_val), .tick_o(tick)
  );

  pscl_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .per_i(per), .one_i(one), .start_i(start),
    .tick_i(tick), .max_i(max_val), .hit_clr_i(hit_clr),
    .cnt_o(cnt), .hit_o(hit), .done_o(done)
  );

  assign irq_o = hit && irq_en;
endmodule

// File: rtl/pscl_timer_chk.sv
`timescale 1ns / 1ps
module pscl_timer_chk
  import pscl_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        wdata_lo_i,
  input logic              per_i,
  input logic              one_i,
  input logic              tick_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  max_i,
  input logic              hit_i
);
  logic wr_ctrl, wr_hit1, end_step;
  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_hit1  = wr_en_i && (addr_i == ADDR_W'(OFS_HIT)) && wdata_lo_i[0];
  assign end_step = (per_i || one_i) && tick_i && (cnt_i == max_i);

  assert_modes_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(per_i && one_i));
  assert_start_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && (wdata_lo_i != 2'b00) |=> (cnt_i == '0) && (per_i || one_i));
  assert_wrap_to_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_i && end_step && !wr_ctrl |=> (cnt_i == '0) && per_i);
  assert_single_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    one_i && end_step && !wr_ctrl |=> !one_i && !per_i && (cnt_i == $past(cnt_i)));
  assert_hold_between_ticks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_ctrl |=> $stable(cnt_i));
  assert_hit_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_step |=> hit_i);
  assert_hit_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit1 && !end_step |=> !hit_i);
endmodule

bind pscl_timer pscl_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_lo_i(wdata_i[1:0]), .per_i(per), .one_i(one), .tick_i(tick),
  .cnt_i(cnt), .max_i(max_val), .hit_i(hit)
);

// File: tb/tb_pscl_timer.sv
`timescale 1ns / 1ps
module tb_pscl_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_err = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  pscl_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    check(tag, {24'b0, v}, {24'b0, exp});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    #1 check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic t_reset();
    rd_chk(4'h0, 8'h00, "R1 ctrl");
    rd_chk(4'h1, 8'h00, "R1 irq enable");
    rd_chk(4'h2, 8'h00, "R1 match flag");
    for (int b = 4; b < 8; b++) rd_chk(4'(b), 8'hFF, "R1 max byte");
    rd_chk(4'h8, 8'h00, "R1 count");
    rd_chk(4'hC, 8'h00, "R1 divide");
    irq_chk(1'b0, "R1 irq");
  endtask

  task automatic t_periodic();
    bus_write(4'h4, 8'h05);
    for (int b = 5; b < 8; b++) bus_write(4'(b), 8'h00);
    rd_chk(4'h4, 8'h05, "R9 max low byte");
    rd_chk(4'h7, 8'h00, "R9 max high byte");
    bus_write(4'h0, 8'h01);              // count 0
    rd_chk(4'h2, 8'h00, "R6 flag clear at start");   // -> 1
    idle(2);                             // 3
    rd_chk(4'h8, 8'h03, "R2 counting");  // -> 4
    idle(2);                             // 5, then wrap to 0
    rd_chk(4'h8, 8'h00, "R2 wrap");      // -> 1
    rd_chk(4'h2, 8'h01, "R6 flag set at max");       // -> 2
    rd_chk(4'h0, 8'h01, "R2 mode kept"); // -> 3
    bus_write(4'h0, 8'h00);              // stops at 4
    idle(5);
    rd_chk(4'h8, 8'h04, "R4 stopped holds");
    rd_chk(4'h0, 8'h00, "R4 stopped ctrl");
    rd_chk(4'h2, 8'h01, "R7 ctrl write 0 keeps flag");
  endtask

  task automatic t_irq();
    irq_chk(1'b0, "R8 irq masked");
    bus_write(4'h1, 8'h01);
    irq_chk(1'b1, "R8 irq enabled");
    bus_write(4'h2, 8'h00);
    rd_chk(4'h2, 8'h01, "R7 write 0 keeps flag");
    bus_write(4'h2, 8'h01);
    irq_chk(1'b0, "R8 irq follows clear");
    rd_chk(4'h2, 8'h00, "R7 write 1 clears flag");
    bus_write(4'h1, 8'h00);
  endtask

  task automatic t_clear_paths();
    bus_write(4'h4, 8'h02);              // max = 2
    bus_write(4'h0, 8'h01);              // 0
    idle(3);                             // 1,2,0 (flag set)
    rd_chk(4'h2, 8'h01, "R6 flag set");  // -> 1
    bus_write(4'h0, 8'h01);              // restart -> 0
    rd_chk(4'h2, 8'h00, "R7 mode set clears flag");  // -> 1
    idle(2);                             // 2, 0 (flag set)
    rd_chk(4'h2, 8'h01, "R6 flag set again");        // -> 1
    bus_write(4'h5, 8'h00);              // -> 2, flag cleared
    rd_chk(4'h2, 8'h00, "R7 max write clears flag");
    bus_write(4'h0, 8'h00);
    bus_write(4'h2, 8'h01);
  endtask

  task automatic t_single();
    bus_write(4'h4, 8'h03);              // max = 3
    bus_write(4'h0, 8'h02);
    idle(10);
    rd_chk(4'h8, 8'h03, "R3 parks at max");
    rd_chk(4'h0, 8'h00, "R3 mode bit self-clears");
    rd_chk(4'h2, 8'h01, "R6 flag on single end");
    bus_write(4'h2, 8'h01);
  endtask

  task automatic t_modes();
    bus_write(4'h4, 8'hFF);              // max = 255
    bus_write(4'h0, 8'h02);
    rd_chk(4'h0, 8'h02, "R4 single selected");
    bus_write(4'h0, 8'h01);
    rd_chk(4'h0, 8'h01, "R4 periodic drops single");
    bus_write(4'h0, 8'h03);
    rd_chk(4'h0, 8'h02, "R4 both written single wins");
    bus_write(4'h0, 8'h01);
    idle(20);
    bus_write(4'h0, 8'h01);
    rd_chk(4'h8, 8'h00, "R4 restart from zero");
    bus_write(4'h0, 8'h00);
  endtask

  task automatic t_prescale();
    bus_write(4'hC, 8'h02);
    rd_chk(4'hC, 8'h02, "R11 divide readback");
    bus_write(4'h0, 8'h01);
    idle(9);
    rd_chk(4'h8, 8'h03, "R5 step every 3 clocks");
    idle(1);
    rd_chk(4'h8, 8'h03, "R5 holds between steps");
    rd_chk(4'h8, 8'h04, "R5 next step");
    bus_write(4'h0, 8'h00);
    bus_write(4'hC, 8'h00);
  endtask

  task automatic t_snapshot();
    for (int b = 4; b < 8; b++) bus_write(4'(b), 8'hFF);
    bus_write(4'h0, 8'h01);              // 0
    idle(300);                           // 300 = 0x12C
    rd_chk(4'h8, 8'h2C, "R10 live low byte");        // latch 0x12C
    idle(300);                           // live 601
    rd_chk(4'h9, 8'h01, "R10 shadow byte 1");
    rd_chk(4'hA, 8'h00, "R10 shadow byte 2");
    rd_chk(4'hB, 8'h00, "R10 shadow byte 3");        // live 604 = 0x25C
    rd_chk(4'h8, 8'h5C, "R10 relatch low byte");
    rd_chk(4'h9, 8'h02, "R10 new shadow byte 1");
    bus_write(4'h0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_irq();
    t_clear_paths();
    t_single();
    t_modes();
    t_prescale();
    t_snapshot();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule